// File: doc/BRIEF.md
# Ultra DMA Read-Burst Opening Sequencer

This block is the host side of the opening handshake for an Ultra DMA read burst on a 16-bit parallel disk bus. It waits for the device to request DMA. It then drives the register address and chip-select lines and holds them for a setup window before it asserts acknowledge. After an envelope delay it releases STOP and asserts host-ready together. Once that has happened, it waits for the device's first strobe transition. If no transition arrives within the first-strobe limit of the selected mode (0 to 5), it raises an error and closes the handshake in order: ready first, then acknowledge.

Every nanosecond limit is turned into a cycle count when the design is elaborated, from the clock period parameter. Minimum delays are rounded up and maximum windows are rounded down. During the burst, the strobe input passes through a synchroniser and an edge detector. The 16-bit bus is captured on both rising and falling strobe transitions, and each capture is reported with a one-cycle valid pulse. When the device drops its request during the data phase, the block negates ready and then releases acknowledge after a hold window.

Top module: `udma_rd_init`

## Requirements
- R1: After reset, acknowledge and host-ready are negated (dmack_n_o=1, hdmardy_n_o=1), STOP is asserted (stop_o=1), and err_o and rd_valid_o are 0.
- R2: On a request seen in the idle state, da_o and cs_n_o take the values of da_i and cs_n_i. Acknowledge falls exactly ceil(20 ns / clock) cycles later (4 cycles at the default 5 ns clock), with the address held stable throughout. After acknowledge is negated, the address may not change for at least ceil(20 ns / clock)+1 cycles.
- R3: STOP falls and host-ready asserts in the same cycle, ceil(20 ns / clock) cycles after acknowledge falls. This is never more than floor(50 ns / clock) cycles after acknowledge, which fits inside every mode's envelope maximum.
- R4: Strobe transitions that occur before acknowledge and ready are active produce no capture.
- R5: While ready is asserted, every rising or falling strobe transition captures dd_i into rd_data_o with one rd_valid_o pulse, in arrival order.
- R6: If no strobe transition arrives within floor(limit / clock) cycles of ready asserting, host-ready is negated and err_o is set. Acknowledge is negated ceil(20 ns / clock) cycles later. The limits for modes 0 to 5 are 230, 200, 170, 130, 120 and 90 ns, which give 46, 40, 34, 26, 24 and 18 cycles at 5 ns.
- R7: If the request drops before acknowledge is asserted, the sequence returns to idle and acknowledge never falls.
- R8: mode_i is sampled only when a sequence starts. The codes 6 and 7 are treated as mode 5.
- R9: If the request drops during the data phase, host-ready is negated on the next clock and STOP is asserted again. Acknowledge is negated ceil(20 ns / clock) cycles after that.
- R10: err_o stays set through idle and clears when the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 3 | Ultra DMA mode, sampled at sequence start |
| da_i | input | AW | Register address to present |
| cs_n_i | input | CSW | Chip-select levels to present |
| dmarq_i | input | 1 | Device DMA request |
| dstrobe_i | input | 1 | Device data strobe |
| dd_i | input | DW | Data bus |
| da_o | output | AW | Address lines |
| cs_n_o | output | CSW | Chip-select lines |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | STOP line |
| hdmardy_n_o | output | 1 | Host ready, active low |
| rd_data_o | output | DW | Captured data word |
| rd_valid_o | output | 1 | One-cycle pulse per captured word |
| err_o | output | 1 | First-strobe timeout flag |

## Verification
The properties assume that the device request and the strobe are driven synchronously to the clock. They also assume that the request stays high from acknowledge until the data phase ends or a timeout occurs. The stimulus changes every input only on the falling clock edge. It holds each data word one cycle ahead of its strobe transition and for several cycles after it. It drops the request only in the address-setup window, in the data phase, or after a timeout has been observed.

// File: rtl/udma_rd_init.sv
module udma_rd_init #(
  parameter int CLK_PS = 5000,
  parameter int DW     = 16,
  parameter int AW     = 3,
  parameter int CSW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     mode_i,
  input  logic [AW-1:0]  da_i,
  input  logic [CSW-1:0] cs_n_i,
  input  logic           dmarq_i,
  input  logic           dstrobe_i,
  input  logic [DW-1:0]  dd_i,
  output logic [AW-1:0]  da_o,
  output logic [CSW-1:0] cs_n_o,
  output logic           dmack_n_o,
  output logic           stop_o,
  output logic           hdmardy_n_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           rd_valid_o,
  output logic           err_o
);

  function automatic int cyc_min(int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int cyc_max(int ps);
    return (ps / CLK_PS < 1) ? 1 : ps / CLK_PS;
  endfunction

  localparam int T_ADDR = cyc_min(20000);
  localparam int T_ENV  = cyc_min(20000);
  localparam int T_HOLD = cyc_min(20000);
  localparam int FS0 = cyc_max(230000);
  localparam int FS1 = cyc_max(200000);
  localparam int FS2 = cyc_max(170000);
  localparam int FS3 = cyc_max(130000);
  localparam int FS4 = cyc_max(120000);
  localparam int FS5 = cyc_max(90000);
  localparam int CW  = $clog2(FS0 + T_HOLD + 2) + 1;

  typedef enum logic [2:0] {
    IDLE, ADDR_SETUP, ACK, ENVELOPE, WAIT_STROBE, DATA, CLOSE, TIMEOUT_ERR
  } st_t;

  st_t st;
  logic [CW-1:0] cnt, fs_lim;
  logic [2:0] mode_q;
  logic [2:0] stb;
  logic [DW-1:0] dd1, dd2;
  logic edge_seen, in_burst;

  assign edge_seen = stb[1] ^ stb[2];
  assign in_burst  = (st == WAIT_STROBE) || (st == DATA);

  assign dmack_n_o   = (st == IDLE) || (st == ADDR_SETUP);
  assign stop_o      = !in_burst;
  assign hdmardy_n_o = !in_burst;

  always_comb begin
    case (mode_q)
      3'd0:    fs_lim = CW'(FS0);
      3'd1:    fs_lim = CW'(FS1);
      3'd2:    fs_lim = CW'(FS2);
      3'd3:    fs_lim = CW'(FS3);
      3'd4:    fs_lim = CW'(FS4);
      default: fs_lim = CW'(FS5);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= '0;
      dd1 <= '0;
      dd2 <= '0;
    end else begin
      stb <= {stb[1:0], dstrobe_i};
      dd1 <= dd_i;
      dd2 <= dd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= CW'(T_HOLD);
      mode_q     <= '0;
      da_o       <= '0;
      cs_n_o     <= '1;
      err_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (in_burst && edge_seen) begin
        rd_valid_o <= 1'b1;
        rd_data_o  <= dd2;
      end
      case (st)
        IDLE: begin
          if (cnt < CW'(T_HOLD)) cnt <= cnt + 1'b1;
          else if (dmarq_i) begin
            st     <= ADDR_SETUP;
            cnt    <= '0;
            da_o   <= da_i;
            cs_n_o <= cs_n_i;
            mode_q <= (mode_i > 3'd5) ? 3'd5 : mode_i;
            err_o  <= 1'b0;
          end
        end
        ADDR_SETUP: begin
          if (!dmarq_i) begin
            st  <= IDLE;
            cnt <= CW'(T_HOLD);
          end else if (cnt == CW'(T_ADDR - 1)) begin
            st  <= ACK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ACK: begin
          st  <= (T_ENV <= 1) ? WAIT_STROBE : ENVELOPE;
          cnt <= '0;
        end
        ENVELOPE: begin
          if (cnt >= CW'(T_ENV - 2)) begin
            st  <= WAIT_STROBE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        WAIT_STROBE: begin
          if (edge_seen) begin
            st  <= DATA;
            cnt <= '0;
          end else if (cnt == fs_lim - 1'b1) begin
            st    <= TIMEOUT_ERR;
            err_o <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        DATA: begin
          if (!dmarq_i) begin
            st  <= CLOSE;
            cnt <= '0;
          end
        end
        default: begin
          if (cnt == CW'(T_HOLD - 1)) begin
            st  <= IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/udma_rd_init_chk.sv
module udma_rd_init_chk #(
  parameter int CLK_PS = 5000,
  parameter int DW     = 16,
  parameter int AW     = 3,
  parameter int CSW    = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dmarq_i,
  input logic [AW-1:0]  da_o,
  input logic [CSW-1:0] cs_n_o,
  input logic           dmack_n_o,
  input logic           stop_o,
  input logic           hdmardy_n_o,
  input logic [DW-1:0]  rd_data_o,
  input logic           rd_valid_o,
  input logic           err_o
);
  localparam int T_ADDR = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int T_ENV  = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int ENVX   = (50000 / CLK_PS < 1) ? 1 : 50000 / CLK_PS;

  logic [7:0] since_addr, ack_age;
  logic [AW-1:0] da_prev;
  logic [CSW-1:0] cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_addr <= '0;
      ack_age    <= '0;
      da_prev    <= '0;
      cs_prev    <= '1;
    end else begin
      da_prev <= da_o;
      cs_prev <= cs_n_o;
      if (da_o != da_prev || cs_n_o != cs_prev) since_addr <= 8'd1;
      else if (since_addr != 8'hff) since_addr <= since_addr + 8'd1;
      if (dmack_n_o) ack_age <= '0;
      else if (ack_age != 8'hff) ack_age <= ack_age + 8'd1;
    end
  end

  a_r2_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmack_n_o) |-> since_addr >= 8'(T_ADDR));

  a_r3_env_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_o) |-> !dmack_n_o && ack_age >= 8'(T_ENV) && ack_age <= 8'(ENVX));

  a_r3_ready_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !hdmardy_n_o |-> !stop_o && !dmack_n_o);

  a_r4_capture_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !dmack_n_o);

  a_r7_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmack_n_o) |-> $past(dmarq_i));

  a_r6_err_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> hdmardy_n_o && !dmack_n_o);

endmodule

bind udma_rd_init udma_rd_init_chk #(.CLK_PS(CLK_PS), .DW(DW), .AW(AW), .CSW(CSW)) chk_i (.*);

// File: tb/udma_rd_init_tb_top.sv
module udma_rd_init_tb_top;
  localparam int CLK_NS = 5;
  localparam int T_SET  = 4;
  localparam int T_HLD  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = '0, da_i = '0;
  logic [1:0] cs_n_i = '1;
  logic dmarq_i = 1'b0, dstrobe_i = 1'b0;
  logic [15:0] dd_i = '0;
  logic [2:0] da_o;
  logic [1:0] cs_n_o;
  logic dmack_n_o, stop_o, hdmardy_n_o, rd_valid_o, err_o;
  logic [15:0] rd_data_o;

  int checks = 0, errors = 0, vcount = 0;
  logic [15:0] exp_q[$];

  always #(CLK_NS * 1.0 / 2) clk = ~clk;

  udma_rd_init dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rd_valid_o) begin
    vcount++;
    if (exp_q.size() == 0) chk(0, "R4 unexpected capture", rd_data_o, 0);
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(rd_data_o == e, "R5 captured word", rd_data_o, e);
    end
  end

  task automatic wait_until_n(input int which, input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((which == 0) ? dmack_n_o : (which == 1) ? hdmardy_n_o : stop_o) != lvl && n < 500);
  endtask

  task automatic send_words(input logic [15:0] w[]);
    foreach (w[i]) begin
      @(negedge clk) dd_i = w[i];
      @(negedge clk) dstrobe_i = ~dstrobe_i;
      exp_q.push_back(w[i]);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic burst(input logic [2:0] m, input logic [2:0] a, input logic [1:0] c,
                       input logic [15:0] w[], input bool_tgl);
    int n, v0;
    @(negedge clk);
    mode_i = m; da_i = a; cs_n_i = c; dmarq_i = 1'b1;
    v0 = vcount;
    if (bool_tgl) begin
      @(negedge clk) dstrobe_i = ~dstrobe_i;
      @(negedge clk) dstrobe_i = ~dstrobe_i;
      wait_until_n(0, 1'b0, n);
      n += 2;
    end else wait_until_n(0, 1'b0, n);
    chk(n == T_SET + 1, "R2 setup to ack cycles", n, T_SET + 1);
    chk(da_o == a && cs_n_o == c, "R2 address at ack", {da_o, cs_n_o}, {a, c});
    chk(vcount == v0, "R4 no capture before ready", vcount - v0, 0);
    wait_until_n(2, 1'b0, n);
    chk(n == T_SET, "R3 ack to stop cycles", n, T_SET);
    chk(hdmardy_n_o == 1'b0, "R3 ready with stop", hdmardy_n_o, 0);
    send_words(w);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && vcount - v0 == w.size(), "R5 all words captured", vcount - v0, w.size());
    dmarq_i = 1'b0;
    wait_until_n(1, 1'b1, n);
    chk(n == 1 && stop_o == 1'b1, "R9 ready off and stop on", n, 1);
    wait_until_n(0, 1'b1, n);
    chk(n == T_HLD, "R9 ack hold cycles", n, T_HLD);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(dmack_n_o && stop_o && hdmardy_n_o && !err_o && !rd_valid_o, "R1 reset levels",
        {dmack_n_o, stop_o, hdmardy_n_o, err_o, rd_valid_o}, 5'b11100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    burst(3'd2, 3'd5, 2'b10, '{16'hA5A5, 16'h5A5A, 16'hFFFF, 16'h0000, 16'h1234}, 1);
    burst(3'd5, 3'd2, 2'b01, '{16'h8001, 16'h8001, 16'h7FFE}, 0);
    burst(3'd3, 3'd7, 2'b00, '{16'hBEEF}, 1);

    // R7 abort in address setup
    @(negedge clk) dmarq_i = 1'b1; mode_i = 3'd0;
    repeat (2) @(negedge clk);
    dmarq_i = 1'b0;
    n = 0;
    repeat (12) begin
      @(negedge clk);
      if (!dmack_n_o) n++;
    end
    chk(n == 0, "R7 no ack after abort", n, 0);

    // R6 timeout in mode 0, request held
    @(negedge clk) da_i = 3'd1; dmarq_i = 1'b1;
    wait_until_n(1, 1'b0, n);
    da_i = 3'd3; mode_i = 3'd7;
    wait_until_n(1, 1'b1, n);
    chk(n == 46, "R6 mode0 timeout cycles", n, 46);
    chk(err_o && !dmack_n_o, "R6 err with ack held", {err_o, dmack_n_o}, 2'b10);
    wait_until_n(0, 1'b1, n);
    chk(n == T_HLD, "R6 ack release after timeout", n, T_HLD);
    chk(err_o == 1'b1, "R10 err kept in idle", err_o, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (da_o != 3'd3 && n < 50);
    chk(n == T_HLD + 1, "R2 address hold after ack", n, T_HLD + 1);
    chk(err_o == 1'b0, "R10 err cleared at start", err_o, 0);
    wait_until_n(1, 1'b0, n);
    mode_i = 3'd0;
    wait_until_n(1, 1'b1, n);
    chk(n == 18, "R8 mode 7 as 5, sampled once", n, 18);
    dmarq_i = 1'b0;
    wait_until_n(0, 1'b1, n);
    repeat (8) @(negedge clk);
    chk(vcount == 9, "R5 total captures", vcount, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule